// File: doc/BRIEF.md
# Power Management Control Register

This block is one byte of a host bridge's configuration space that holds the bridge's power-management enables. Software reaches it through configuration reads and writes at one fixed byte offset. Its stored bits drive control outputs for the rest of the bridge: a refresh enable for the memory controller, a clock-gating request, an interface-disable level, and a permission for the processor-reset logic to fire without a bus reset.

Two bits do not behave like ordinary storage. The interface-disable bit comes from a strap pin. The block samples that pin while bus reset is held and ignores writes to the bit. The processor-reset permission bit normally clears on bus reset. It keeps its value when the reset arrives while the platform reports a suspend state.

The block also decodes processor I/O cycles. A cycle to the one control port at 0x0022 is claimed by the bridge when the control-port enable is set. Any other I/O cycle, or any cycle while that enable is clear, is marked for forwarding downstream.

Top module: `pm_ctrl_reg`

## Requirements
- R1: While `rst_n` is low, the register is loaded with 0x00, except that bit 1 takes the value of `strap_link_off`. Bit 0 follows R9.
- R2: Bit 1 holds the strap value seen at the last reset clock edge. It does not follow later changes of `strap_link_off`, and configuration writes to it have no effect.
- R3: A write to offset 0x7A with `cfg_wr` and `cfg_byte_en` both high loads `cfg_wdata` bits 6, 4, 2 and 0 at the next rising edge. A write with `cfg_byte_en` low, or to any other offset, leaves the register unchanged.
- R4: Bits 7, 5 and 3 always read as 0, and writing 1 to them has no effect.
- R5: `cfg_rdata` shows the full register byte in the same cycle when `cfg_rd` is high and `cfg_addr` is 0x7A. Otherwise it is 0x00.
- R6: `io_claim` is high exactly when `io_valid` is high, `io_addr` equals 0x0022 and bit 6 is 1. `io_forward` is high exactly when `io_valid` is high and `io_claim` is low.
- R7: An address that differs from 0x0022 in any bit, for example 0x0023 or 0x1022, is never claimed.
- R8: `clk_gate_req` is high exactly when bit 2 is 1 and `bus_idle_all` is high.
- R9: Bus reset clears bit 0, except that a reset taken while `suspend_active` is high leaves bit 0 unchanged. Bits 6, 4 and 2 clear in either case.
- R10: `refresh_en` follows bit 4. `ctl_port_en` follows bit 6, `link_off` follows bit 1 and `cpu_rst_alone_en` follows bit 0. After any reset, `refresh_en` stays low until software writes bit 4 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low, synchronous |
| strap_link_off | input | 1 | Strap level sampled during reset into bit 1 |
| suspend_active | input | 1 | High while a suspend state is active; spares bit 0 from reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_byte_en | input | 1 | Byte enable for the addressed byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_rdata | output | 8 | Read data, combinational |
| io_valid | input | 1 | Current processor cycle is an I/O cycle |
| io_addr | input | 16 | I/O cycle address |
| bus_idle_all | input | 1 | All buses detected idle |
| io_claim | output | 1 | Bridge claims the I/O cycle |
| io_forward | output | 1 | I/O cycle is forwarded downstream |
| ctl_port_en | output | 1 | Bit 6: control port enabled |
| refresh_en | output | 1 | Bit 4: normal refresh enabled |
| clk_gate_req | output | 1 | Dynamic clock gating requested |
| link_off | output | 1 | Bit 1: graphics link disabled |
| cpu_rst_alone_en | output | 1 | Bit 0: processor reset without bus reset allowed |

## Verification
Writes and resets reach the register, and every output derived from it, one rising edge after the cycle in which they are presented. Reads, the I/O claim and forward flags, and the gating request are combinational and are due in the same cycle as their inputs. The bench drives every input on the falling edge. For a combinational result it samples 1 ns later. For a stored result it first lets one rising edge pass and then samples after the next falling edge. The strap is changed only after reset is released, which shows that the value captured at the last reset edge is the one that stays.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_CTL   = 6;
    localparam int BIT_REFR  = 4;
    localparam int BIT_GATE  = 2;
    localparam int BIT_LINK  = 1;
    localparam int BIT_CRST  = 0;

    // Software-writable fields.
    typedef struct packed {
        logic ctl;
        logic refr;
        logic gate;
        logic crst;
    } pm_wr_t;

    // Full stored state, including the strap-loaded field.
    typedef struct packed {
        logic ctl;
        logic refr;
        logic gate;
        logic link;
        logic crst;
    } pm_state_t;

endpackage

// File: rtl/pm_cfg_store.sv
module pm_cfg_store
    import pm_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap_in,
    input  logic      suspend_in,
    input  logic      wr_hit,
    input  pm_wr_t    wr_val,
    output pm_state_t st_q
);

    pm_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d      = '0;
            st_d.link = strap_in;
            st_d.crst = suspend_in ? st_q.crst : 1'b0;
        end else if (wr_hit) begin
            st_d.ctl  = wr_val.ctl;
            st_d.refr = wr_val.refr;
            st_d.gate = wr_val.gate;
            st_d.crst = wr_val.crst;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R3: an accepted write lands on the next edge
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (st_q.ctl == $past(wr_val.ctl) && st_q.refr == $past(wr_val.refr) &&
                    st_q.gate == $past(wr_val.gate) && st_q.crst == $past(wr_val.crst)));

    // R3: without a write the writable fields hold
    assert_no_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(st_q.ctl) && $stable(st_q.refr) &&
                     $stable(st_q.gate) && $stable(st_q.crst)));

    // R2: the strap-loaded field never moves outside reset
    assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(st_q.link));

    // R9: a reset outside suspend leaves the reset-permission bit clear
    assert_crst_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !$past(suspend_in)) |-> !st_q.crst);

endmodule

// File: rtl/pm_cfg_port.sv
module pm_cfg_port
    import pm_ctrl_pkg::*;
#(
    parameter logic [REG_W-1:0] REG_OFFSET = 8'h7A
) (
    input  logic [REG_W-1:0] cfg_addr,
    input  logic             cfg_wr,
    input  logic             cfg_byte_en,
    input  logic             cfg_rd,
    input  logic [REG_W-1:0] cfg_wdata,
    input  pm_state_t        st,
    output logic             wr_hit,
    output pm_wr_t           wr_val,
    output logic [REG_W-1:0] rdata
);

    logic sel;
    logic unused_wbits;

    assign sel    = (cfg_addr == REG_OFFSET);
    assign wr_hit = sel && cfg_wr && cfg_byte_en;

    assign wr_val.ctl  = cfg_wdata[BIT_CTL];
    assign wr_val.refr = cfg_wdata[BIT_REFR];
    assign wr_val.gate = cfg_wdata[BIT_GATE];
    assign wr_val.crst = cfg_wdata[BIT_CRST];

    // Reserved and strap-owned bits are dropped on write.
    assign unused_wbits = ^{cfg_wdata[7], cfg_wdata[5], cfg_wdata[3], cfg_wdata[BIT_LINK]};

    always_comb begin
        rdata = '0;
        if (sel && cfg_rd) begin
            rdata[BIT_CTL]  = st.ctl;
            rdata[BIT_REFR] = st.refr;
            rdata[BIT_GATE] = st.gate;
            rdata[BIT_LINK] = st.link;
            rdata[BIT_CRST] = st.crst;
        end
    end

endmodule

// File: rtl/pm_io_claim.sv
module pm_io_claim #(
    parameter int                   IO_ADDR_W = 16,
    parameter logic [IO_ADDR_W-1:0] CTL_PORT  = 16'h0022
) (
    input  logic                 io_valid,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 ctl_en,
    output logic                 claim,
    output logic                 forward
);

    logic [IO_ADDR_W-1:0] bit_eq;

    for (genvar g = 0; g < IO_ADDR_W; g++) begin : g_cmp
        assign bit_eq[g] = (io_addr[g] == CTL_PORT[g]);
    end

    assign claim   = io_valid && ctl_en && (&bit_eq);
    assign forward = io_valid && !claim;

endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
    import pm_ctrl_pkg::*;
#(
    parameter int                   IO_ADDR_W  = 16,
    parameter logic [REG_W-1:0]     REG_OFFSET = 8'h7A,
    parameter logic [IO_ADDR_W-1:0] CTL_PORT   = 16'h0022
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_link_off,
    input  logic                 suspend_active,
    input  logic [REG_W-1:0]     cfg_addr,
    input  logic                 cfg_wr,
    input  logic                 cfg_byte_en,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 cfg_rd,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 io_valid,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 bus_idle_all,
    output logic                 io_claim,
    output logic                 io_forward,
    output logic                 ctl_port_en,
    output logic                 refresh_en,
    output logic                 clk_gate_req,
    output logic                 link_off,
    output logic                 cpu_rst_alone_en
);

    pm_state_t st_q;
    pm_wr_t    wr_val;
    logic      wr_hit;

    pm_cfg_port #(.REG_OFFSET(REG_OFFSET)) i_port (
        .cfg_addr    (cfg_addr),
        .cfg_wr      (cfg_wr),
        .cfg_byte_en (cfg_byte_en),
        .cfg_rd      (cfg_rd),
        .cfg_wdata   (cfg_wdata),
        .st          (st_q),
        .wr_hit      (wr_hit),
        .wr_val      (wr_val),
        .rdata       (cfg_rdata)
    );

    pm_cfg_store i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_in   (strap_link_off),
        .suspend_in (suspend_active),
        .wr_hit     (wr_hit),
        .wr_val     (wr_val),
        .st_q       (st_q)
    );

    pm_io_claim #(.IO_ADDR_W(IO_ADDR_W), .CTL_PORT(CTL_PORT)) i_claim (
        .io_valid (io_valid),
        .io_addr  (io_addr),
        .ctl_en   (st_q.ctl),
        .claim    (io_claim),
        .forward  (io_forward)
    );

    assign ctl_port_en      = st_q.ctl;
    assign refresh_en       = st_q.refr;
    assign link_off         = st_q.link;
    assign cpu_rst_alone_en = st_q.crst;
    assign clk_gate_req     = st_q.gate && bus_idle_all;

    // R6: a claim needs the stored control-port enable and an I/O cycle
    assert_claim_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_claim |-> (ctl_port_en && io_valid));

    // R6: claim and forward are exclusive
    assert_claim_fwd_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_claim && io_forward));

    // R7: only the exact port is claimed
    assert_claim_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_claim |-> (io_addr == CTL_PORT));

    // R8: gating is requested only when every bus is idle
    assert_gate_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_req |-> bus_idle_all);

    // R4: reserved bits read back as zero
    assert_rsv_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7] == 1'b0 && cfg_rdata[5] == 1'b0 && cfg_rdata[3] == 1'b0));

    // R5: no read strobe, no read data
    assert_rd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |-> (cfg_rdata == '0));

    // R5: a read of the offset shows the refresh field that the output carries
    assert_rd_refr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == REG_OFFSET) |-> (cfg_rdata[BIT_REFR] == refresh_en));

endmodule

// File: tb/test_pm_ctrl_reg.sv
module test_pm_ctrl_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_link_off = 1'b1;
    logic        suspend_active = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic        cfg_wr = 1'b0;
    logic        cfg_byte_en = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_rdata;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        bus_idle_all = 1'b0;
    logic        io_claim, io_forward, ctl_port_en, refresh_en;
    logic        clk_gate_req, link_off, cpu_rst_alone_en;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pm_ctrl_reg i_pm_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .strap_link_off(strap_link_off),
        .suspend_active(suspend_active), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_byte_en(cfg_byte_en), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
        .cfg_rdata(cfg_rdata), .io_valid(io_valid), .io_addr(io_addr),
        .bus_idle_all(bus_idle_all), .io_claim(io_claim), .io_forward(io_forward),
        .ctl_port_en(ctl_port_en), .refresh_en(refresh_en),
        .clk_gate_req(clk_gate_req), .link_off(link_off),
        .cpu_rst_alone_en(cpu_rst_alone_en)
    );

    typedef struct packed {
        logic        wr;
        logic        be;
        logic [7:0]  addr;
        logic [7:0]  wdata;
        logic [15:0] ioa;
        logic        iov;
        logic        idle;
        logic [7:0]  exp_rd;
        logic        exp_claim;
        logic        exp_gate;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 8'h7A, 8'hFF, 16'h0022, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1}, // R3 R4
        '{1'b1, 1'b1, 8'h7A, 8'h00, 16'h0022, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}, // R3 R6
        '{1'b1, 1'b1, 8'h7A, 8'h44, 16'h0022, 1'b1, 1'b0, 8'h44, 1'b1, 1'b0}, // R6 R8
        '{1'b1, 1'b0, 8'h7A, 8'h00, 16'h0023, 1'b1, 1'b1, 8'h44, 1'b0, 1'b1}, // R3 R7
        '{1'b1, 1'b1, 8'h7B, 8'h00, 16'h1022, 1'b1, 1'b1, 8'h44, 1'b0, 1'b1}, // R3 R7
        '{1'b0, 1'b1, 8'h7A, 8'h00, 16'h0022, 1'b0, 1'b1, 8'h44, 1'b0, 1'b1}, // R6
        '{1'b1, 1'b1, 8'h7A, 8'h12, 16'h0022, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0}, // R2 R10
        '{1'b1, 1'b1, 8'h7A, 8'h0A, 16'h0022, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}  // R2 R4
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d, input logic be);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1; cfg_byte_en = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_byte_en = 1'b0;
    endtask

    task automatic read_now(output logic [7:0] v);
        cfg_addr = 8'h7A; cfg_rd = 1'b1;
        #1 v = cfg_rdata;
        cfg_rd = 1'b0;
    endtask

    task automatic do_reset(input logic strap, input logic susp);
        @(negedge clk);
        rst_n = 1'b0; strap_link_off = strap; suspend_active = susp;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        suspend_active = 1'b0;
        strap_link_off = ~strap;
    endtask

    initial begin
        logic [7:0] rv;
        // reset with strap high
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strap_link_off = 1'b0;
        read_now(rv);
        chk("R1 reset value", {8'h0, rv}, 16'h0002);
        chk("R1 link_off after reset", {15'h0, link_off}, 16'h1);
        chk("R10 refresh_en low after reset", {15'h0, refresh_en}, 16'h0);

        // R2: strap moved, writes to bit 1 ignored
        cfg_write(8'h7A, 8'hFF, 1'b1);
        read_now(rv);
        chk("R2 strap bit kept under write", {8'h0, rv}, 16'h0057);
        chk("R10 refresh_en after write", {15'h0, refresh_en}, 16'h1);
        chk("R10 ctl_port_en after write", {15'h0, ctl_port_en}, 16'h1);
        chk("R10 cpu_rst_alone_en after write", {15'h0, cpu_rst_alone_en}, 16'h1);

        // R9: reset during suspend keeps bit 0
        do_reset(1'b1, 1'b1);
        read_now(rv);
        chk("R9 bit0 kept in suspend reset", {8'h0, rv}, 16'h0003);
        chk("R10 refresh_en cleared by reset", {15'h0, refresh_en}, 16'h0);

        // R9: ordinary reset clears bit 0; R1 strap low
        do_reset(1'b0, 1'b0);
        read_now(rv);
        chk("R9 bit0 cleared by reset", {8'h0, rv}, 16'h0000);
        chk("R1 link_off strap low", {15'h0, link_off}, 16'h0);

        // table walk (strap captured low)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_addr = TBL[i].addr; cfg_wdata = TBL[i].wdata;
            cfg_wr = TBL[i].wr; cfg_byte_en = TBL[i].be;
            @(negedge clk);
            cfg_wr = 1'b0; cfg_byte_en = 1'b0;
            io_addr = TBL[i].ioa; io_valid = TBL[i].iov; bus_idle_all = TBL[i].idle;
            read_now(rv);
            chk($sformatf("R3 R4 vector %0d read", i), {8'h0, rv}, {8'h0, TBL[i].exp_rd});
            chk($sformatf("R6 R7 vector %0d claim", i), {15'h0, io_claim}, {15'h0, TBL[i].exp_claim});
            chk($sformatf("R6 vector %0d forward", i), {15'h0, io_forward},
                {15'h0, TBL[i].iov & ~TBL[i].exp_claim});
            chk($sformatf("R8 vector %0d gate", i), {15'h0, clk_gate_req}, {15'h0, TBL[i].exp_gate});
            chk($sformatf("R10 vector %0d refresh", i), {15'h0, refresh_en}, {15'h0, TBL[i].exp_rd[4]});
            chk($sformatf("R2 vector %0d link_off", i), {15'h0, link_off}, 16'h0);
        end

        // R5: read gating
        cfg_write(8'h7A, 8'h55, 1'b1);
        cfg_addr = 8'h7A; cfg_rd = 1'b0;
        #1 chk("R5 no strobe reads zero", {8'h0, cfg_rdata}, 16'h0000);
        cfg_addr = 8'h7B; cfg_rd = 1'b1;
        #1 chk("R5 other offset reads zero", {8'h0, cfg_rdata}, 16'h0000);
        cfg_addr = 8'h7A;
        #1 chk("R5 same-cycle read", {8'h0, cfg_rdata}, 16'h0055);
        cfg_rd = 1'b0;

        // R8: gate follows idle combinationally
        bus_idle_all = 1'b0;
        #1 chk("R8 gate off when busy", {15'h0, clk_gate_req}, 16'h0);
        bus_idle_all = 1'b1;
        #1 chk("R8 gate on when idle", {15'h0, clk_gate_req}, 16'h1);

        // R7: one-bit-off upper address not claimed, exact one claimed
        io_valid = 1'b1; io_addr = 16'h8022;
        #1 chk("R7 high bit differs", {15'h0, io_claim}, 16'h0);
        io_addr = 16'h0022;
        #1 chk("R6 exact port claimed", {15'h0, io_claim}, 16'h1);
        io_valid = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule